// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for a four-phase dual-slope integrating converter. Each measurement cycle steps through a fixed sequence: system zero (auto-zero), signal integrate, reference integrate and integrator zero. In every phase the block selects exactly one analog switch group. It samples the integrator comparator once per clock. It counts reference-integrate clocks up to the zero crossing and latches the result as a five-digit BCD reading, together with polarity and range flags.

A run/hold input chooses between free-running conversions and held operation. In held operation the last reading stays on the outputs, and a single high pulse starts exactly one new cycle. Every cycle has the same length whatever the input amplitude. Reference-integrate time that the crossing leaves unused is spent in integrator zero. After an overrange, the start of the next auto-zero window is given to integrator zero so that the integrator can recover.

Timing is set by one parameter, the signal-integrate length S, which is 10,000 by default. Auto-zero lasts S+1 clocks. The reference window (reference integrate plus integrator zero) lasts 2S+1 clocks. The full cycle is 4S+2 clocks.

Top module: `dsadc_seq`

## Requirements
- R1: After reset, and after every cycle boundary taken with `runHold` high, the switch selects run in a fixed order: auto-zero (`swAutoZero`) for S+1 clocks, then signal integrate (`swInput`) for S clocks, then a reference window of 2S+1 clocks. This makes the cycle 4S+2 clocks. Exactly one of the five switch outputs is high in every clock.
- R2: During the reference window, `swRefPos` is high when `polarity` is 1 and `swRefNeg` is high when `polarity` is 0. This lasts until `busy` falls. `swIntZero` is high for the rest of the window.
- R3: When a cycle ends in overrange, the first `IZ_EXT` clocks (6,200 by default) of the next auto-zero window select `swIntZero` instead of `swAutoZero`. This happens whether or not a hold interval comes in between.
- R4: `busy` is low during auto-zero. It rises with the first signal-integrate clock. It falls in the clock after the comparator first shows the crossing, or at the end of the reference window if no crossing occurs.
- R5: `cmpIn` is registered once per clock. The first reference-integrate clock is not counted. So if `cmpIn` first shows the crossing in reference clock k (counting from 0), the latched reading is k. `reading` holds decimal digit i in bits 4i+3..4i, with digit 0 the least significant.
- R6: `polarity` is the value of `cmpIn` in the last signal-integrate clock, where 1 means a positive input. It is loaded at the start of reference integrate and held until the next reference integrate.
- R7: If no crossing is seen by the last clock of the 2S+1 window, `overRange` is set and `reading` is set to 0 when `busy` falls. `overRange` is cleared at the start of the next reference integrate.
- R8: When `busy` falls after a crossing, `underRange` is set if the reading is at most `UNDER_LIM` (1,800 by default). It is never set on an overrange. It is cleared at the start of the next signal integrate.
- R9: `reading`, `overRange` and `underRange` change only on the edge at which `busy` falls (apart from the clears in R7 and R8). `latchLoad` is high for exactly the one clock after that edge.
- R10: If `runHold` is low in the last clock of a cycle, the block stops after that cycle. It selects `swAutoZero`, keeps `busy` low and holds the latched outputs.
- R11: While holding, `runHold` high for one clock starts one new cycle, beginning with auto-zero. A pulse on `runHold` that ends before the running cycle completes has no effect.
- R12: While `rstN` is low, the block selects `swAutoZero` with every other output at 0, and it leaves reset at the start of auto-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Active-low synchronous reset |
| runHold | input | 1 | 1 = convert continuously; 0 = hold after the current cycle; a pulse while holding starts one cycle |
| cmpIn | input | 1 | Comparator output, 1 when the integrator is on the positive side |
| swAutoZero | output | 1 | Select system-zero switches |
| swInput | output | 1 | Select signal-input switches |
| swRefPos | output | 1 | Select positive reference switch |
| swRefNeg | output | 1 | Select negative reference switch |
| swIntZero | output | 1 | Select integrator-zero switches |
| busy | output | 1 | High from signal integrate until the crossing is detected |
| overRange | output | 1 | Last reading exceeded the reference window |
| underRange | output | 1 | Last reading was at or below the lower limit |
| polarity | output | 1 | Sign of the input, 1 = positive |
| latchLoad | output | 1 | One-clock pulse after new results are latched |
| reading | output | 20 | Five BCD digits of the latched count |

## Verification
If the phase counter holds a wrong value, the switch outputs and the rising edge of `busy` move off their expected clocks in the very next phase. The clock-by-clock model catches this within one clock of the error. A missed count inhibit, or a wrongly timed comparator register, shows up only when the reading is latched, as a reading one count too high or too low. So crossings are placed at 0, at the underrange limit and the count just above it, and at the last valid count. A lost overrange flag shows up as a missing integrator-zero stretch at the start of the following auto-zero window, and the model checks this on every clock of that window.

// File: rtl/dsadc_pkg.sv
`timescale 1ns/1ps
package dsadc_pkg;
  localparam int DIGITS = 5;

  typedef struct packed {
    logic siStart;   // entering signal integrate
    logic riStart;   // entering reference integrate
    logic countEn;   // advance the reading counter
    logic busyEnd;   // crossing seen or window exhausted
    logic overFlow;  // window exhausted without a crossing
  } seqStrobe_t;

  function automatic logic [4*DIGITS-1:0] binToBcd(input logic [31:0] v);
    logic [31:0] rem;
    logic [4*DIGITS-1:0] res;
    rem = v;
    res = '0;
    for (int i = 0; i < DIGITS; i++) begin
      res[4*i +: 4] = 4'(rem % 10);
      rem = rem / 10;
    end
    return res;
  endfunction
endpackage

// File: rtl/dsadc_ctrl.sv
`timescale 1ns/1ps
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int SIG_LEN = 10000,
  parameter int IZ_EXT  = 6200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runHold,
  input  logic       zeroCross,
  output seqStrobe_t stb,
  output logic       selAutoZero,
  output logic       selInput,
  output logic       selRef,
  output logic       selIntZero
);
  localparam int AZ_LEN  = SIG_LEN + 1;
  localparam int REF_WIN = 2 * SIG_LEN + 1;
  localparam int CW      = $clog2(REF_WIN + 1);
  localparam logic [CW-1:0] AZ_LAST  = CW'(AZ_LEN - 1);
  localparam logic [CW-1:0] SI_LAST  = CW'(SIG_LEN - 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(REF_WIN - 1);
  localparam logic [CW-1:0] EXT_N    = CW'(IZ_EXT);

  typedef enum logic [2:0] {S_AZ, S_SI, S_RI, S_IZ, S_HOLD} seqState_t;

  seqState_t   state;
  logic [CW-1:0] cnt;
  logic        extPend;
  logic        endCycle;
  logic        inExt;

  always_comb begin
    stb      = '0;
    endCycle = 1'b0;
    case (state)
      S_AZ: stb.siStart = (cnt == AZ_LAST);
      S_SI: stb.riStart = (cnt == SI_LAST);
      S_RI: begin
        stb.countEn  = (cnt != '0) && !zeroCross;
        stb.busyEnd  = zeroCross || (cnt == WIN_LAST);
        stb.overFlow = !zeroCross && (cnt == WIN_LAST);
        endCycle     = (cnt == WIN_LAST);
      end
      S_IZ:    endCycle = (cnt == WIN_LAST);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_AZ;
      cnt     <= '0;
      extPend <= 1'b0;
    end else begin
      case (state)
        S_AZ: begin
          if (stb.siStart) begin
            state   <= S_SI;
            cnt     <= '0;
            extPend <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SI: begin
          if (stb.riStart) begin
            state <= S_RI;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RI, S_IZ: begin
          if (stb.overFlow) extPend <= 1'b1;
          if (endCycle) begin
            state <= runHold ? S_AZ : S_HOLD;
            cnt   <= '0;
          end else begin
            if (stb.busyEnd) state <= S_IZ;
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (runHold) begin
            state <= S_AZ;
            cnt   <= '0;
          end
        end
        default: state <= S_AZ;
      endcase
    end
  end

  assign inExt       = (state == S_AZ) && extPend && (cnt < EXT_N);
  assign selIntZero  = (state == S_IZ) || inExt;
  assign selAutoZero = (state == S_HOLD) || ((state == S_AZ) && !inExt);
  assign selInput    = (state == S_SI);
  assign selRef      = (state == S_RI);
endmodule

// File: rtl/dsadc_data.sv
`timescale 1ns/1ps
module dsadc_data
  import dsadc_pkg::*;
#(
  parameter int SIG_LEN   = 10000,
  parameter int UNDER_LIM = 1800
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmpIn,
  input  seqStrobe_t          stb,
  output logic                zeroCross,
  output logic                busy,
  output logic                polarity,
  output logic                overRange,
  output logic                underRange,
  output logic                latchLoad,
  output logic [4*DIGITS-1:0] reading
);
  localparam int CW = $clog2(2 * SIG_LEN + 2);

  logic          cmpQ;
  logic [CW-1:0] count;

  assign zeroCross = (cmpQ != polarity);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ       <= 1'b0;
      count      <= '0;
      busy       <= 1'b0;
      polarity   <= 1'b0;
      overRange  <= 1'b0;
      underRange <= 1'b0;
      latchLoad  <= 1'b0;
      reading    <= '0;
    end else begin
      cmpQ      <= cmpIn;
      latchLoad <= stb.busyEnd;
      if (stb.riStart)      count <= '0;
      else if (stb.countEn) count <= count + 1'b1;
      if (stb.siStart) begin
        busy       <= 1'b1;
        underRange <= 1'b0;
      end
      if (stb.riStart) begin
        polarity  <= cmpIn;
        overRange <= 1'b0;
      end
      if (stb.busyEnd) begin
        busy       <= 1'b0;
        overRange  <= stb.overFlow;
        underRange <= !stb.overFlow && (count <= CW'(UNDER_LIM));
        reading    <= stb.overFlow ? '0 : binToBcd(32'(count));
      end
    end
  end
endmodule

// File: rtl/dsadc_seq.sv
`timescale 1ns/1ps
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int SIG_LEN   = 10000,
  parameter int UNDER_LIM = 1800,
  parameter int IZ_EXT    = 6200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runHold,
  input  logic        cmpIn,
  output logic        swAutoZero,
  output logic        swInput,
  output logic        swRefPos,
  output logic        swRefNeg,
  output logic        swIntZero,
  output logic        busy,
  output logic        overRange,
  output logic        underRange,
  output logic        polarity,
  output logic        latchLoad,
  output logic [19:0] reading
);
  seqStrobe_t stb;
  logic       zeroCross;
  logic       selRef;

  dsadc_ctrl #(.SIG_LEN(SIG_LEN), .IZ_EXT(IZ_EXT)) ctrl_i (
    .clk(clk), .rstN(rstN), .runHold(runHold), .zeroCross(zeroCross), .stb(stb),
    .selAutoZero(swAutoZero), .selInput(swInput), .selRef(selRef), .selIntZero(swIntZero)
  );

  dsadc_data #(.SIG_LEN(SIG_LEN), .UNDER_LIM(UNDER_LIM)) data_i (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .stb(stb), .zeroCross(zeroCross),
    .busy(busy), .polarity(polarity), .overRange(overRange), .underRange(underRange),
    .latchLoad(latchLoad), .reading(reading)
  );

  assign swRefPos = selRef & polarity;
  assign swRefNeg = selRef & ~polarity;
endmodule

// File: rtl/dsadc_seq_chk.sv
`timescale 1ns/1ps
module dsadc_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        runHold,
  input logic        cmpIn,
  input logic        swAutoZero,
  input logic        swInput,
  input logic        swRefPos,
  input logic        swRefNeg,
  input logic        swIntZero,
  input logic        busy,
  input logic        overRange,
  input logic        underRange,
  input logic        polarity,
  input logic        latchLoad,
  input logic [19:0] reading
);
  // R1: exactly one switch group selected
  p_onehot_sw_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({swAutoZero, swInput, swRefPos, swRefNeg, swIntZero}));

  // R4: busy never high while auto-zero is selected
  p_busy_not_az_r4: assert property (@(posedge clk) disable iff (!rstN)
    swAutoZero |-> !busy);

  // R4: busy rises only as signal integrate starts
  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> swInput);

  // R6: polarity steady within a reference integrate
  p_pol_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((swRefPos || swRefNeg) && $past(swRefPos || swRefNeg)) |-> $stable(polarity));

  // R7: an overrange reading is all zero
  p_ovr_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (reading == 20'd0));

  // R8: both range flags never together
  p_range_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(overRange && underRange));

  // R9: load pulse follows the fall of busy
  p_load_after_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    latchLoad |-> $fell(busy));

  // R9: reading changes only with a load
  p_reading_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !latchLoad |-> $stable(reading));
endmodule

bind dsadc_seq dsadc_seq_chk chk_i (.*);

// File: tb/dsadc_seq_tb_top.sv
`timescale 1ns/1ps
module dsadc_seq_tb_top;
  localparam int SIG = 100;
  localparam int UL  = 18;
  localparam int EXT = 62;
  localparam int AZL = SIG + 1;
  localparam int WIN = 2 * SIG + 1;
  localparam int CYC = AZL + SIG + WIN;
  localparam int NP  = 12;

  logic clk = 1'b0, rstN = 1'b0, runHold = 1'b1, cmpIn = 1'b0;
  logic swAutoZero, swInput, swRefPos, swRefNeg, swIntZero;
  logic busy, overRange, underRange, polarity, latchLoad;
  logic [19:0] reading;

  dsadc_seq #(.SIG_LEN(SIG), .UNDER_LIM(UL), .IZ_EXT(EXT)) dut_i (
    .clk(clk), .rstN(rstN), .runHold(runHold), .cmpIn(cmpIn),
    .swAutoZero(swAutoZero), .swInput(swInput), .swRefPos(swRefPos),
    .swRefNeg(swRefNeg), .swIntZero(swIntZero), .busy(busy),
    .overRange(overRange), .underRange(underRange), .polarity(polarity),
    .latchLoad(latchLoad), .reading(reading)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // per-cycle plans: polarity, crossing clock k, run level, mid-cycle pulse, hold wait
  int pPol[NP]  = '{1, 0, 1, 1, 1, 0, 1, 1, 0, 1, 0, 1};
  int pK[NP]    = '{50, 10, 18, 19, 0, 199, 200, 150, 1000, 123, 77, 5};
  int pRh[NP]   = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 0, 1};
  int pPulse[NP]= '{-1, -1, 60, -1, -1, -1, -1, -1, 60, -1, -1, -1};
  int pWait[NP] = '{0, 0, 0, 0, 0, 0, 0, 0, 30, 0, 7, 0};

  int mHold, mT, mExt, holdCnt, planIdx;
  int curPol, curK, curRh, curPulse, curWait;
  int eBusy, ePol, eOvr, eUnd, eRd, eLL;

  task automatic chk(string tag, string what, longint act, longint exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [19:0] toBcd(int v);
    logic [19:0] r = '0;
    int x = v;
    for (int i = 0; i < 5; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic [4:0] expSw();
    if (mHold != 0) return 5'b10000;
    if (mT < AZL) return (mExt != 0 && mT < EXT) ? 5'b00001 : 5'b10000;
    if (mT < AZL + SIG) return 5'b01000;
    if (eBusy != 0) return (ePol != 0) ? 5'b00100 : 5'b00010;
    return 5'b00001;
  endfunction

  task automatic comparePeriod();
    string swTag;
    if (mHold != 0) swTag = (curPulse >= 0) ? "R11 hold" : "R10 hold";
    else if (mT < AZL) swTag = (mExt != 0 && mT < EXT) ? "R3 extension" : "R1 auto-zero";
    else if (mT < AZL + SIG) swTag = "R1 signal";
    else swTag = "R2 reference window";
    chk(swTag, "switches", {swAutoZero, swInput, swRefPos, swRefNeg, swIntZero}, expSw());
    chk("R4", "busy", busy, eBusy);
    chk("R6", "polarity", polarity, ePol);
    chk("R7", "overRange", overRange, eOvr);
    chk("R8", "underRange", underRange, eUnd);
    chk("R9", "latchLoad", latchLoad, eLL);
    chk("R5", "reading", reading, toBcd(eRd));
  endtask

  task automatic stepModel(int rh);
    int r;
    int nLL = 0;
    if (mHold != 0) begin
      if (rh != 0) begin mHold = 0; mT = 0; end
    end else begin
      if (mT == AZL - 1) begin eBusy = 1; eUnd = 0; mExt = 0; end
      else if (mT == AZL + SIG - 1) begin ePol = curPol; eOvr = 0; end
      else if (mT >= AZL + SIG && eBusy != 0) begin
        r = mT - AZL - SIG;
        if (r >= curK + 1) begin
          eBusy = 0; eRd = curK; eUnd = (curK <= UL) ? 1 : 0; nLL = 1;
        end else if (r == WIN - 1) begin
          eBusy = 0; eRd = 0; eOvr = 1; eUnd = 0; nLL = 1; mExt = 1;
        end
      end
      if (mT == CYC - 1) begin
        if (rh != 0) mT = 0;
        else begin mHold = 1; holdCnt = 0; end
      end else mT++;
    end
    eLL = nLL;
  endtask

  initial begin
    int rh;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "reset switches", {swAutoZero, swInput, swRefPos, swRefNeg, swIntZero}, 5'b10000);
    chk("R12", "reset flags", {busy, overRange, underRange, polarity, latchLoad}, 5'b0);
    chk("R12", "reset reading", reading, 0);
    mHold = 0; mT = 0; mExt = 0; holdCnt = 0; planIdx = 0;
    eBusy = 0; ePol = 0; eOvr = 0; eUnd = 0; eRd = 0; eLL = 0;
    curPol = 0; curK = 0; curRh = 1; curPulse = -1; curWait = 0;
    rstN = 1'b1;
    while (1) begin
      comparePeriod();
      if (mHold == 0 && mT == 0) begin
        if (planIdx == NP) break;
        curPol = pPol[planIdx]; curK = pK[planIdx]; curRh = pRh[planIdx];
        curPulse = pPulse[planIdx]; curWait = pWait[planIdx];
        planIdx++;
      end
      if (mHold != 0) begin
        rh = (holdCnt == curWait) ? 1 : 0;
        holdCnt++;
        cmpIn = 1'b0;
      end else begin
        rh = (mT == curPulse) ? 1 : curRh;
        if (mT < AZL + SIG) cmpIn = curPol[0];
        else cmpIn = ((mT - AZL - SIG) >= curK) ? !curPol[0] : curPol[0];
      end
      runHold = rh[0];
      stepModel(rh);
      @(negedge clk);
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule